// File: doc/BRIEF.md
# Queued Sparse Multiply-Accumulate Unit

This block is the arithmetic back end of one processing element in a sparse matrix-vector engine. Nonzero activations are broadcast to many elements at once. Each element places the incoming (value, column index) pairs in a short local queue, so an element with a lot of work does not hold up the others. The broadcaster is stalled only when this queue has no room.

The oldest queued activation is presented to a weight decoder through `head_index`. The decoder returns a stream of (decoded weight, accumulator row) pairs for that column and flags the last pair, which retires the queue entry. Each accepted pair performs `b[row] += (weight * activation) >>> FRAC_W` with a saturating 16-bit result, in a 64-entry accumulator file.

The update runs in two stages: read and multiply, then add and write-back. When consecutive updates hit the same row, the pending sum is forwarded so that no update is lost. A clear input zeroes the file. A combinational read port returns any entry once the pipeline is idle.

Top module: `sparse_mac_unit`

## Requirements
- R1: After reset, `act_ready`=1, `q_empty`=1, `q_full`=0, `head_valid`=0, `pipe_busy`=0, and every one of the 64 accumulators reads 0.
- R2: An activation is stored when `act_valid` and `act_ready` are both high at a rising edge. `act_ready` is low, and `q_full` is high, exactly when Q_DEPTH (default 8) entries are held. An offer made while the queue is full is dropped. `q_empty` is high when no entry is held.
- R3: Entries leave the queue in arrival order. `head_index` and the head value used by the multiplier belong to the oldest entry. An entry is removed by an accepted weight that has `wt_last`=1.
- R4: `wt_ready` equals `head_valid && !clr`. A weight offered while `wt_ready` is low changes no accumulator and does not pop the queue.
- R5: An accepted weight `w` for row `x`, with head value `a` (both signed 16-bit two's complement), sets `b[x]` to `b[x] + ((w*a) >>> FRAC_W)`, where `>>>` is an arithmetic right shift of the full 32-bit product and FRAC_W defaults to 8. The new value is visible on `rd_data` after the second rising edge that follows acceptance.
- R6: The sum is saturated to the range 16'h8000 (−32768) to 16'h7FFF (32767).
- R7: Updates to the same row on consecutive cycles all accumulate, with none lost. Updates to alternating rows also all accumulate.
- R8: A cycle with `clr`=1 zeroes all accumulators at the next edge and discards an update that is still in flight.
- R9: `pipe_busy` is high for the one cycle after each accepted weight, while its write-back is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Zero all accumulators |
| act_valid | input | 1 | Broadcast activation offered |
| act_value | input | 16 | Activation value, signed fixed point |
| act_index | input | 12 | Activation column index |
| act_ready | output | 1 | Queue has room |
| q_full | output | 1 | Queue holds Q_DEPTH entries |
| q_empty | output | 1 | Queue holds no entry |
| head_valid | output | 1 | An activation is waiting at the head |
| head_index | output | 12 | Column index of the head activation |
| wt_valid | input | 1 | Decoded weight offered |
| wt_value | input | 16 | Decoded weight, signed fixed point |
| wt_row | input | 6 | Accumulator row for this weight |
| wt_last | input | 1 | Last weight of the head column |
| wt_ready | output | 1 | Weight accepted this cycle if valid |
| rd_row | input | 6 | Accumulator row to read |
| rd_data | output | 16 | Contents of the selected accumulator |
| pipe_busy | output | 1 | A write-back is pending |

## Verification
The assertions assume that the decoder never offers a weight against an empty queue. They also assume that `clr` is only one-cycle pulses, and that a read is only trusted when `pipe_busy` is low.

The stimulus keeps to these assumptions. It always pushes an activation before sending its weights, and it samples `rd_data` only after the write-back edge. The one deliberate exception is the offer made to an empty queue, where the bench checks that the offer has no effect.

Inputs are driven on falling edges, so every accept and write-back edge is known in advance.

// File: rtl/smac_pkg.sv
package smac_pkg;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned ROW_W   = 6;
    localparam int unsigned ENTRIES = 1 << ROW_W;
    localparam int unsigned AIDX_W  = 12;

    typedef struct packed {
        logic [AIDX_W-1:0] index;
        logic [DATA_W-1:0] value;
    } act_entry_t;
endpackage

// File: rtl/smac_act_queue.sv
module smac_act_queue
    import smac_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  act_entry_t push_data,
    output logic       push_ready,
    input  logic       pop,
    output logic       head_valid,
    output act_entry_t head_data,
    output logic       full,
    output logic       empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        act_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]       wr_ptr;
        logic [PTR_W-1:0]       rd_ptr;
        logic [CNT_W-1:0]       count;
    } q_state_t;

    q_state_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push_valid && (st_q.count != CNT_MAX);
        do_pop  = pop && (st_q.count != '0);
        if (do_push) begin
            st_d.mem[st_q.wr_ptr] = push_data;
            st_d.wr_ptr = (st_q.wr_ptr == PTR_LAST) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_LAST) ? '0 : st_q.rd_ptr + 1'b1;
        end
        if (do_push && !do_pop) begin
            st_d.count = st_q.count + 1'b1;
        end else if (do_pop && !do_push) begin
            st_d.count = st_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full       = (st_q.count == CNT_MAX);
    assign empty      = (st_q.count == '0);
    assign push_ready = !full;
    assign head_valid = !empty;
    assign head_data  = st_q.mem[st_q.rd_ptr];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_MAX); // R2
    AST_FULL_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(push_valid)); // R2
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R4
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop && head_valid) |=> $stable(head_data)); // R3
endmodule

// File: rtl/smac_acc_pipe.sv
module smac_acc_pipe
    import smac_pkg::*;
#(
    parameter int unsigned FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_act,
    input  logic [DATA_W-1:0] in_wt,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int unsigned PROD_W = 2 * DATA_W;
    localparam int unsigned SUM_W  = PROD_W + 1;
    localparam logic [SUM_W-1:0] SAT_HI = {{(SUM_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic [SUM_W-1:0] SAT_LO = {{(SUM_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [ENTRIES-1:0][DATA_W-1:0] rf;
        logic                           s1_valid;
        logic [ROW_W-1:0]               s1_row;
        logic [DATA_W-1:0]              s1_base;
        logic [PROD_W-1:0]              s1_prod;
    } p_state_t;

    p_state_t                 st_d, st_q;
    logic signed [PROD_W-1:0] prod_full, prod_sh;
    logic [SUM_W-1:0]         raw_sum;
    logic [DATA_W-1:0]        wb_sat;
    logic                     fwd_hit;

    always_comb begin
        // stage 2: add the held product to the held base and clamp
        raw_sum = {{(SUM_W-DATA_W){st_q.s1_base[DATA_W-1]}}, st_q.s1_base}
                + {st_q.s1_prod[PROD_W-1], st_q.s1_prod};
        if ($signed(raw_sum) > $signed(SAT_HI)) begin
            wb_sat = SAT_HI[DATA_W-1:0];
        end else if ($signed(raw_sum) < $signed(SAT_LO)) begin
            wb_sat = SAT_LO[DATA_W-1:0];
        end else begin
            wb_sat = raw_sum[DATA_W-1:0];
        end

        // stage 1: multiply, scale, read base with forwarding
        prod_full = $signed(in_act) * $signed(in_wt);
        prod_sh   = prod_full >>> FRAC_W;
        fwd_hit   = st_q.s1_valid && (st_q.s1_row == in_row);

        st_d          = st_q;
        st_d.s1_valid = in_valid;
        st_d.s1_row   = in_row;
        st_d.s1_prod  = prod_sh;
        st_d.s1_base  = fwd_hit ? wb_sat : st_q.rf[in_row];
        if (st_q.s1_valid) begin
            st_d.rf[st_q.s1_row] = wb_sat;
        end
        if (clr) begin
            st_d.rf       = '0;
            st_d.s1_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rf[rd_row];
    assign busy    = st_q.s1_valid;

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.rf == '0) && !busy); // R8
    AST_WB_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && !clr) |=> st_q.rf[$past(st_q.s1_row)] == $past(wb_sat)); // R5
    AST_SAT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && !st_q.s1_base[DATA_W-1] && !st_q.s1_prod[PROD_W-1])
            |-> !wb_sat[DATA_W-1]); // R6
    AST_FWD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr && st_q.s1_valid && (st_q.s1_row == in_row))
            |=> st_q.s1_base == $past(wb_sat)); // R7
endmodule

// File: rtl/sparse_mac_unit.sv
module sparse_mac_unit
    import smac_pkg::*;
#(
    parameter int unsigned Q_DEPTH = 8,
    parameter int unsigned FRAC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              act_valid,
    input  logic [DATA_W-1:0] act_value,
    input  logic [AIDX_W-1:0] act_index,
    output logic              act_ready,
    output logic              q_full,
    output logic              q_empty,
    output logic              head_valid,
    output logic [AIDX_W-1:0] head_index,
    input  logic              wt_valid,
    input  logic [DATA_W-1:0] wt_value,
    input  logic [ROW_W-1:0]  wt_row,
    input  logic              wt_last,
    output logic              wt_ready,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_data,
    output logic              pipe_busy
);
    act_entry_t push_ent, head_ent;
    logic       take, retire;

    assign push_ent.index = act_index;
    assign push_ent.value = act_value;
    assign wt_ready   = head_valid && !clr;
    assign take       = wt_valid && wt_ready;
    assign retire     = take && wt_last;
    assign head_index = head_ent.index;

    smac_act_queue #(.DEPTH(Q_DEPTH)) i_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (act_valid),
        .push_data  (push_ent),
        .push_ready (act_ready),
        .pop        (retire),
        .head_valid (head_valid),
        .head_data  (head_ent),
        .full       (q_full),
        .empty      (q_empty)
    );

    smac_acc_pipe #(.FRAC_W(FRAC_W)) i_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (take),
        .in_act   (head_ent.value),
        .in_wt    (wt_value),
        .in_row   (wt_row),
        .rd_row   (rd_row),
        .rd_data  (rd_data),
        .busy     (pipe_busy)
    );

    AST_READY_VS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        act_ready |-> !q_full); // R2
endmodule

// File: tb/test_sparse_mac_unit.sv
`timescale 1ns/1ps
module test_sparse_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        act_valid = 1'b0;
    logic [15:0] act_value = '0;
    logic [11:0] act_index = '0;
    logic        act_ready, q_full, q_empty, head_valid, wt_ready, pipe_busy;
    logic [11:0] head_index;
    logic        wt_valid = 1'b0;
    logic [15:0] wt_value = '0;
    logic [5:0]  wt_row = '0;
    logic        wt_last = 1'b0;
    logic [5:0]  rd_row = '0;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sparse_mac_unit i_sparse_mac_unit (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .act_valid(act_valid), .act_value(act_value), .act_index(act_index),
        .act_ready(act_ready), .q_full(q_full), .q_empty(q_empty),
        .head_valid(head_valid), .head_index(head_index),
        .wt_valid(wt_valid), .wt_value(wt_value), .wt_row(wt_row),
        .wt_last(wt_last), .wt_ready(wt_ready),
        .rd_row(rd_row), .rd_data(rd_data), .pipe_busy(pipe_busy)
    );

    // {activation, weight, row, expected accumulator after the update}, FRAC_W = 8
    localparam logic [53:0] VEC [8] = '{
        {16'h0100, 16'h0200, 6'd3,  16'h0200},
        {16'h0080, 16'hFF00, 6'd3,  16'h0180},
        {16'h7FFF, 16'h7FFF, 6'd10, 16'h7FFF},
        {16'h8000, 16'h7FFF, 6'd63, 16'h8000},
        {16'h0300, 16'h0040, 6'd0,  16'h00C0},
        {16'hFFF0, 16'h0010, 6'd0,  16'h00BF},
        {16'h0001, 16'h0001, 6'd5,  16'h0000},
        {16'hFFFF, 16'h0001, 6'd5,  16'hFFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [5:0] r, output logic [15:0] v);
        rd_row = r;
        #0.5;
        v = rd_data;
    endtask

    task automatic push_act(input logic [15:0] v, input logic [11:0] idx);
        act_valid = 1'b1; act_value = v; act_index = idx;
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic send_wt(input logic [15:0] w, input logic [5:0] r, input logic last);
        wt_valid = 1'b1; wt_value = w; wt_row = r; wt_last = last;
        @(negedge clk);
        wt_valid = 1'b0; wt_last = 1'b0;
    endtask

    initial begin
        #(5.0 * 50000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int nz;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 act_ready", act_ready, 1);
        check("R1 q_empty", q_empty, 1);
        check("R1 q_full", q_full, 0);
        check("R1 head_valid", head_valid, 0);
        check("R1 pipe_busy", pipe_busy, 0);
        nz = 0;
        for (int r = 0; r < 64; r++) begin
            peek(r[5:0], v);
            if (v != 0) nz++;
        end
        check("R1 nonzero rows", nz, 0);

        // R5 R6 vector table
        for (int i = 0; i < 8; i++) begin
            push_act(VEC[i][53:38], 12'(i));
            check("R3 head_index", head_index, i);
            send_wt(VEC[i][37:22], VEC[i][21:16], 1'b1);
            check("R9 busy after accept", pipe_busy, 1);
            @(negedge clk);
            check("R9 busy after write", pipe_busy, 0);
            peek(VEC[i][21:16], v);
            check((i == 2 || i == 3) ? "R6 saturate" : "R5 update", v, VEC[i][15:0]);
        end

        // R2 R3 fill the queue, then one extra offer
        for (int k = 0; k < 8; k++) push_act(16'(16'h10 * (k + 1)), 12'(100 + k));
        check("R2 q_full", q_full, 1);
        check("R2 act_ready low", act_ready, 0);
        push_act(16'h7777, 12'd999);
        for (int k = 0; k < 8; k++) begin
            check("R3 fifo order", head_index, 100 + k);
            send_wt(16'h0100, 6'(20 + k), 1'b1);
        end
        @(negedge clk);
        check("R2 dropped offer", q_empty, 1);
        for (int k = 0; k < 8; k++) begin
            peek(6'(20 + k), v);
            check("R3 head value", v, 16'h10 * (k + 1));
        end

        // R4 weight on empty queue
        wt_valid = 1'b1; wt_value = 16'h0100; wt_row = 6'd30; wt_last = 1'b1;
        #0.5;
        check("R4 wt_ready empty", wt_ready, 0);
        @(negedge clk);
        wt_valid = 1'b0; wt_last = 1'b0;
        @(negedge clk);
        peek(6'd30, v);
        check("R4 no update", v, 0);

        // R4 weight during clear is refused and does not pop
        push_act(16'h0100, 12'd40);
        clr = 1'b1;
        wt_valid = 1'b1; wt_value = 16'h0100; wt_row = 6'd31; wt_last = 1'b1;
        #0.5;
        check("R4 wt_ready clr", wt_ready, 0);
        @(negedge clk);
        clr = 1'b0; wt_valid = 1'b0; wt_last = 1'b0;
        check("R4 no pop", head_valid, 1);
        peek(6'd20, v);
        check("R8 clr zeroes", v, 0);
        send_wt(16'h0100, 6'd31, 1'b1);
        @(negedge clk);
        peek(6'd31, v);
        check("R4 later accept", v, 16'h0100);

        // R7 same row back to back
        push_act(16'h0100, 12'd41);
        wt_valid = 1'b1; wt_value = 16'h0100; wt_row = 6'd7;
        repeat (3) @(negedge clk);
        wt_last = 1'b1;
        @(negedge clk);
        wt_valid = 1'b0; wt_last = 1'b0;
        @(negedge clk);
        peek(6'd7, v);
        check("R7 bypass", v, 16'h0400);

        // R7 alternating rows
        push_act(16'h0100, 12'd42);
        wt_valid = 1'b1; wt_value = 16'h0100;
        wt_row = 6'd8; @(negedge clk);
        wt_row = 6'd9; @(negedge clk);
        wt_row = 6'd8; @(negedge clk);
        wt_row = 6'd9; wt_last = 1'b1; @(negedge clk);
        wt_valid = 1'b0; wt_last = 1'b0;
        @(negedge clk);
        peek(6'd8, v);
        check("R7 alternate row8", v, 16'h0200);
        peek(6'd9, v);
        check("R7 alternate row9", v, 16'h0200);

        // R8 clear with an update in flight
        push_act(16'h0100, 12'd43);
        send_wt(16'h0100, 6'd12, 1'b1);
        check("R9 in flight", pipe_busy, 1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        peek(6'd12, v);
        check("R8 in-flight dropped", v, 0);
        peek(6'd7, v);
        check("R8 other row zero", v, 0);
        check("R8 busy cleared", pipe_busy, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule